// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block sits beside the issue logic of an out-of-order core. It keeps a small table of the loads, stores and memory barriers that are in flight and decides when each load or store may go to the memory pipeline. When an operation is inserted it is tied to at most one producer. That producer is the youngest active barrier that applies to the operation's kind. If no barrier applies, it is the store whose sequence number an external dependence predictor supplies with the insert. Each entry then waits until two things are true: its register operands are ready and its memory dependence is resolved.

Entries that are ready are offered one at a time on an output handshake, oldest sequence number first. A single command channel carries the other events, all addressed by sequence number:
- register-ready notices
- non-speculative release
- completion of a store, load or barrier, which wakes dependents and frees the slot
- reschedule and replay of issued operations
- squash of younger operations of one thread

Top module: `memdep_tracker`

## Requirements
- R1: After reset the table is empty, nothing is offered (`rdy_valid` low), both barriers are inactive and `ins_ready` is high.
- R2: An operation is encoded by `ins_kind` as 0 load, 1 store, 2 full barrier, 3 write barrier. A load or store inserted with no producer becomes ready as soon as its register flag is set. A predicted sequence number of 0, or one that names no store or barrier present in the table, means no producer. If `ins_regs_ok` is high at insert, the operation is offered in the cycle after the insert edge.
- R3: A load or store whose producer is present waits until that producer completes. At completion it is offered at once if its register flag is already set; otherwise it is offered after a later register-ready command (`cmd_op` 0).
- R4: An inserted full barrier makes later loads and stores depend on it. An inserted write barrier makes only later stores depend on it; loads bypass it.
- R5: Completing a barrier wakes its dependents and removes it. A barrier flag is cleared only when its recorded sequence number equals the completing barrier's number, so an older barrier completing leaves a younger one in force.
- R6: While an applicable barrier is active, it replaces the predictor input as the producer.
- R7: A squash (`cmd_op` 5) with number S and thread T removes every entry of thread T whose sequence number is greater than S. Removed entries are never offered, even when their producer later completes. Entries of other threads and entries not younger than S are untouched.
- R8: A reschedule (`cmd_op` 3) queues an issued operation for replay. A replay (`cmd_op` 4) makes every queued operation ready in the same cycle and empties the queue. A squash also drops queued operations that it removes.
- R9: An operation inserted with `ins_nonspec` high is offered only after a non-speculative-ready command (`cmd_op` 1). A register-ready command alone does not release it.
- R10: At most one entry is offered per cycle, and it is the ready entry with the lowest sequence number. The offer stays unchanged until `rdy_take` is seen high at a clock edge.
- R11: `ins_ready` is low while the table is full or while `cmd_valid` is high.
- R12: Only stores and barriers wake dependents. A prediction that names a load is treated as no producer.
- R13: Completion (`cmd_op` 2) removes the entry and frees its slot for a new insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted at this edge when high |
| ins_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_tid | input | TID_W | Thread of the inserted operation |
| ins_pred | input | SEQ_W | Predicted producing store, 0 for none |
| ins_regs_ok | input | 1 | Register operands already ready at insert |
| ins_nonspec | input | 1 | Insert as non-speculative |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 regs ready, 1 non-spec ready, 2 complete, 3 reschedule, 4 replay, 5 squash |
| cmd_seq | input | SEQ_W | Target sequence number, or squash bound S |
| cmd_tid | input | TID_W | Thread for squash |
| rdy_valid | output | 1 | An entry is offered for issue |
| rdy_take | input | 1 | Consumer takes the offered entry |
| rdy_seq | output | SEQ_W | Sequence number of the offered entry |
| rdy_tid | output | TID_W | Thread of the offered entry |
| rdy_kind | output | 2 | Kind of the offered entry |

## Verification
A wrong table state shows up at the ready port, usually within one or two cycles of the event that should have changed it. A lost wakeup shows up as an operation that is never offered after its producer completes. A stale or squashed entry shows up as an extra offer. A wrong barrier flag shows up as a later load or store that is offered too early or held too long. The scoreboard matches every offer against the predicted order of sequence numbers. It also requires that nothing is offered in windows where every waiting entry should still be blocked, so a missing offer and an extra offer are both caught.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_FULLBAR = 2'd2,
        K_WRBAR   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        OP_REGS     = 3'd0,
        OP_NSREADY  = 3'd1,
        OP_COMPLETE = 3'd2,
        OP_RESCHED  = 3'd3,
        OP_REPLAY   = 3'd4,
        OP_SQUASH   = 3'd5
    } op_e;

    function automatic logic is_barrier(kind_e k);
        return (k == K_FULLBAR) || (k == K_WRBAR);
    endfunction

    // stores and barriers are the only kinds that may release dependents
    function automatic logic can_wake(kind_e k);
        return k != K_LOAD;
    endfunction

    function automatic logic holds_loads(kind_e k);
        return k == K_FULLBAR;
    endfunction

endpackage

// File: rtl/memdep_seq_cam.sv
module memdep_seq_cam #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            mask,
    input  logic [N-1:0][SEQ_W-1:0] seqs,
    input  logic [SEQ_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && seqs[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_free_pick.sv
module memdep_free_pick #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_oldest_pick.sv
module memdep_oldest_pick #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][SEQ_W-1:0] seqs,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || seqs[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = seqs[i];
            end
        end
    end
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
    import memdep_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int SEQ_W   = 16,
    parameter int TID_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [1:0]       ins_kind,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [TID_W-1:0] ins_tid,
    input  logic [SEQ_W-1:0] ins_pred,
    input  logic             ins_regs_ok,
    input  logic             ins_nonspec,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic [TID_W-1:0] cmd_tid,
    output logic             rdy_valid,
    input  logic             rdy_take,
    output logic [SEQ_W-1:0] rdy_seq,
    output logic [TID_W-1:0] rdy_tid,
    output logic [1:0]       rdy_kind
);
    localparam int IDX_W = $clog2(ENTRIES);

    // entry table
    logic [ENTRIES-1:0]             e_vld, e_sq, e_regs, e_memok, e_inrdy, e_rsch, e_pvld;
    logic [ENTRIES-1:0][1:0]        e_kind;
    logic [ENTRIES-1:0][SEQ_W-1:0]  e_seq;
    logic [ENTRIES-1:0][TID_W-1:0]  e_tid;
    logic [ENTRIES-1:0][IDX_W-1:0]  e_pidx;

    logic [ENTRIES-1:0]             n_vld, n_sq, n_regs, n_memok, n_inrdy, n_rsch, n_pvld;
    logic [ENTRIES-1:0][1:0]        n_kind;
    logic [ENTRIES-1:0][SEQ_W-1:0]  n_seq;
    logic [ENTRIES-1:0][TID_W-1:0]  n_tid;
    logic [ENTRIES-1:0][IDX_W-1:0]  n_pidx;

    // barrier state
    logic             lb_act, sb_act, n_lb_act, n_sb_act;
    logic [SEQ_W-1:0] lb_seq, sb_seq, n_lb_seq, n_sb_seq;

    kind_e ins_k;
    op_e   op;
    assign ins_k = kind_e'(ins_kind);
    assign op    = op_e'(cmd_op);

    // slot allocation
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    memdep_free_pick #(.N(ENTRIES)) u_free (
        .busy     (e_vld),
        .any_free (any_free),
        .idx      (free_idx)
    );

    assign ins_ready = any_free && !cmd_valid;

    logic ins_fire;
    assign ins_fire = ins_valid && ins_ready;

    // command target lookup
    logic             cmd_hit;
    logic [IDX_W-1:0] cmd_idx;

    memdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cmd_cam (
        .mask (e_vld),
        .seqs (e_seq),
        .key  (cmd_seq),
        .hit  (cmd_hit),
        .idx  (cmd_idx)
    );

    // producer lookup: barrier first, predictor otherwise
    logic [SEQ_W-1:0]   prod_key;
    logic [ENTRIES-1:0] prod_mask;
    logic               prod_hit_raw;
    logic [IDX_W-1:0]   prod_idx;

    always_comb begin
        if (ins_k == K_LOAD && lb_act)
            prod_key = lb_seq;
        else if (ins_k == K_STORE && sb_act)
            prod_key = sb_seq;
        else
            prod_key = ins_pred;
        for (int i = 0; i < ENTRIES; i++)
            prod_mask[i] = e_vld[i] && !e_sq[i] && can_wake(kind_e'(e_kind[i]));
    end

    memdep_seq_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_prod_cam (
        .mask (prod_mask),
        .seqs (e_seq),
        .key  (prod_key),
        .hit  (prod_hit_raw),
        .idx  (prod_idx)
    );

    logic prod_hit;
    assign prod_hit = prod_hit_raw && (prod_key != '0);

    // issue selection
    logic [ENTRIES-1:0] offer_cand;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            offer_cand[i] = e_vld[i] && e_inrdy[i] && !is_barrier(kind_e'(e_kind[i]));
    end

    memdep_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick (
        .cand  (offer_cand),
        .seqs  (e_seq),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign rdy_valid = pick_found;
    assign rdy_seq   = pick_found ? e_seq[pick_idx]  : '0;
    assign rdy_tid   = pick_found ? e_tid[pick_idx]  : '0;
    assign rdy_kind  = pick_found ? e_kind[pick_idx] : 2'd0;

    // next-state
    always_comb begin
        n_vld   = e_vld;   n_sq    = e_sq;    n_regs = e_regs;
        n_memok = e_memok; n_inrdy = e_inrdy; n_rsch = e_rsch;
        n_pvld  = e_pvld;  n_kind  = e_kind;  n_seq  = e_seq;
        n_tid   = e_tid;   n_pidx  = e_pidx;
        n_lb_act = lb_act; n_lb_seq = lb_seq;
        n_sb_act = sb_act; n_sb_seq = sb_seq;

        if (pick_found && rdy_take)
            n_inrdy[pick_idx] = 1'b0;

        if (ins_fire) begin
            n_vld[free_idx]   = 1'b1;
            n_sq[free_idx]    = 1'b0;
            n_kind[free_idx]  = ins_kind;
            n_seq[free_idx]   = ins_seq;
            n_tid[free_idx]   = ins_tid;
            n_regs[free_idx]  = ins_regs_ok;
            n_rsch[free_idx]  = 1'b0;
            n_inrdy[free_idx] = 1'b0;
            n_pvld[free_idx]  = 1'b0;
            n_pidx[free_idx]  = '0;
            n_memok[free_idx] = 1'b0;
            if (is_barrier(ins_k)) begin
                n_sb_act = 1'b1;
                n_sb_seq = ins_seq;
                if (holds_loads(ins_k)) begin
                    n_lb_act = 1'b1;
                    n_lb_seq = ins_seq;
                end
            end else if (!ins_nonspec) begin
                if (prod_hit) begin
                    n_pvld[free_idx] = 1'b1;
                    n_pidx[free_idx] = prod_idx;
                end else begin
                    n_memok[free_idx] = 1'b1;
                    n_inrdy[free_idx] = ins_regs_ok;
                end
            end
        end

        if (cmd_valid) begin
            case (op)
                OP_REGS: if (cmd_hit) begin
                    n_regs[cmd_idx] = 1'b1;
                    if (e_memok[cmd_idx])
                        n_inrdy[cmd_idx] = 1'b1;
                end
                OP_NSREADY: if (cmd_hit)
                    n_inrdy[cmd_idx] = 1'b1;
                OP_RESCHED: if (cmd_hit)
                    n_rsch[cmd_idx] = 1'b1;
                OP_REPLAY: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (e_vld[i] && e_rsch[i]) begin
                            n_inrdy[i] = 1'b1;
                            n_rsch[i]  = 1'b0;
                        end
                    end
                end
                OP_COMPLETE: if (cmd_hit) begin
                    if (can_wake(kind_e'(e_kind[cmd_idx]))) begin
                        for (int j = 0; j < ENTRIES; j++) begin
                            if (e_pvld[j] && e_pidx[j] == cmd_idx && !e_sq[j]) begin
                                n_pvld[j] = 1'b0;
                                if (e_regs[j])
                                    n_inrdy[j] = 1'b1;
                                else
                                    n_memok[j] = 1'b1;
                            end
                        end
                    end
                    n_vld[cmd_idx]   = 1'b0;
                    n_inrdy[cmd_idx] = 1'b0;
                    n_rsch[cmd_idx]  = 1'b0;
                    if (is_barrier(kind_e'(e_kind[cmd_idx]))) begin
                        if (sb_seq == e_seq[cmd_idx])
                            n_sb_act = 1'b0;
                        if (holds_loads(kind_e'(e_kind[cmd_idx])) && lb_seq == e_seq[cmd_idx])
                            n_lb_act = 1'b0;
                    end
                end
                OP_SQUASH: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (e_vld[i] && e_tid[i] == cmd_tid && e_seq[i] > cmd_seq) begin
                            n_vld[i]   = 1'b0;
                            n_sq[i]    = 1'b1;
                            n_inrdy[i] = 1'b0;
                            n_rsch[i]  = 1'b0;
                            n_pvld[i]  = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_vld <= '0; e_sq <= '0; e_regs <= '0; e_memok <= '0;
            e_inrdy <= '0; e_rsch <= '0; e_pvld <= '0;
            e_kind <= '0; e_seq <= '0; e_tid <= '0; e_pidx <= '0;
            lb_act <= 1'b0; lb_seq <= '0;
            sb_act <= 1'b0; sb_seq <= '0;
        end else begin
            e_vld <= n_vld; e_sq <= n_sq; e_regs <= n_regs; e_memok <= n_memok;
            e_inrdy <= n_inrdy; e_rsch <= n_rsch; e_pvld <= n_pvld;
            e_kind <= n_kind; e_seq <= n_seq; e_tid <= n_tid; e_pidx <= n_pidx;
            lb_act <= n_lb_act; lb_seq <= n_lb_seq;
            sb_act <= n_sb_act; sb_seq <= n_sb_seq;
        end
    end

    // ---------------- assertions ----------------
    logic older_offerable;
    always_comb begin
        older_offerable = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (offer_cand[i] && e_seq[i] < rdy_seq)
                older_offerable = 1'b1;
    end

    // R10: the offer is never younger than another offerable entry
    a_r10_oldest_first: assert property (@(posedge clk) disable iff (rst)
        rdy_valid |-> !older_offerable);

    // R10: an untaken offer stays put when nothing else happens
    a_r10_offer_held: assert property (@(posedge clk) disable iff (rst)
        (rdy_valid && !rdy_take && !cmd_valid && !ins_valid) |=>
        (rdy_valid && rdy_seq == $past(rdy_seq)));

    // R4: barriers are never presented for issue
    a_r4_no_barrier_offer: assert property (@(posedge clk) disable iff (rst)
        rdy_valid |-> !is_barrier(kind_e'(rdy_kind)));

    // R11: a full table refuses inserts
    a_r11_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (&e_vld) |-> !ins_ready);

    // R5: completing a barrier that is not the recorded one keeps the store barrier
    a_r5_flag_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_COMPLETE && cmd_hit && sb_act &&
         is_barrier(kind_e'(e_kind[cmd_idx])) && e_seq[cmd_idx] != sb_seq) |=> sb_act);

    // R7: no younger entry of the squashed thread survives a squash
    logic             chk_sq_pend;
    logic [SEQ_W-1:0] chk_sq_seq;
    logic [TID_W-1:0] chk_sq_tid;
    logic             sq_survivor;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_sq_pend <= 1'b0;
            chk_sq_seq  <= '0;
            chk_sq_tid  <= '0;
        end else begin
            chk_sq_pend <= cmd_valid && op == OP_SQUASH;
            chk_sq_seq  <= cmd_seq;
            chk_sq_tid  <= cmd_tid;
        end
    end

    always_comb begin
        sq_survivor = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (e_vld[i] && e_tid[i] == chk_sq_tid && e_seq[i] > chk_sq_seq)
                sq_survivor = 1'b1;
    end

    a_r7_squash_clears: assert property (@(posedge clk) disable iff (rst)
        chk_sq_pend |-> !sq_survivor);

endmodule

// File: tb/memdep_tracker_tb_top.sv
module memdep_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 0, ins_regs_ok = 0, ins_nonspec = 0;
    logic        ins_ready;
    logic [1:0]  ins_kind = 0;
    logic [15:0] ins_seq = 0, ins_pred = 0;
    logic [0:0]  ins_tid = 0;
    logic        cmd_valid = 0;
    logic [2:0]  cmd_op = 0;
    logic [15:0] cmd_seq = 0;
    logic [0:0]  cmd_tid = 0;
    logic        rdy_valid;
    logic        take_en = 1'b1;
    logic [15:0] rdy_seq;
    logic [0:0]  rdy_tid;
    logic [1:0]  rdy_kind;

    always #5 clk = ~clk;

    memdep_tracker dut_i (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_kind(ins_kind),
        .ins_seq(ins_seq), .ins_tid(ins_tid), .ins_pred(ins_pred),
        .ins_regs_ok(ins_regs_ok), .ins_nonspec(ins_nonspec),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_seq(cmd_seq), .cmd_tid(cmd_tid),
        .rdy_valid(rdy_valid), .rdy_take(take_en), .rdy_seq(rdy_seq),
        .rdy_tid(rdy_tid), .rdy_kind(rdy_kind)
    );

    typedef struct {
        logic [15:0] seq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FB = 2'd2, WB = 2'd3;
    localparam logic [2:0] C_REGS = 3'd0, C_NS = 3'd1, C_DONE = 3'd2,
                           C_RESCH = 3'd3, C_REPLAY = 3'd4, C_SQUASH = 3'd5;

    task automatic expect_offer(input logic [15:0] s, input string tag);
        exp_t e;
        e.seq = s;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ins(input logic [1:0] k, input logic [15:0] s, input logic [15:0] p,
                       input logic regs, input logic [0:0] t, input logic ns);
        @(posedge clk); #2;
        ins_valid = 1; ins_kind = k; ins_seq = s; ins_pred = p;
        ins_regs_ok = regs; ins_tid = t; ins_nonspec = ns;
        @(posedge clk); #2;
        ins_valid = 0; ins_nonspec = 0; ins_regs_ok = 0;
    endtask

    task automatic cmd(input logic [2:0] o, input logic [15:0] s, input logic [0:0] t);
        @(posedge clk); #2;
        cmd_valid = 1; cmd_op = o; cmd_seq = s; cmd_tid = t;
        @(posedge clk); #2;
        cmd_valid = 0;
    endtask

    task automatic drained(input string tag);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && rdy_valid && take_en) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R7/R10 unexpected offer actual=%0d expected=none", rdy_seq);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rdy_seq !== e.seq) begin
                    n_fails++;
                    $display("FAIL %s actual=%0d expected=%0d", e.tag, rdy_seq, e.seq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        // R1
        check(rdy_valid == 0, "R1 rdy_valid after reset", rdy_valid, 0);
        check(ins_ready == 1, "R1 ins_ready after reset", ins_ready, 1);

        // R11: command blocks insert
        @(posedge clk); #2;
        cmd_valid = 1; cmd_op = C_REGS; cmd_seq = 16'd999;
        @(negedge clk);
        check(ins_ready == 0, "R11 ins_ready during command", ins_ready, 0);
        @(posedge clk); #2 cmd_valid = 0;

        // R2
        expect_offer(16'd5, "R2 no producer, regs at insert");
        ins(LD, 16'd5, 16'd0, 1, 0, 0);
        ins(LD, 16'd6, 16'd0, 0, 0, 0);
        drained("R2 waits for regs");
        expect_offer(16'd6, "R2 regs-ready releases");
        cmd(C_REGS, 16'd6, 0);
        drained("R2 drained");
        cmd(C_DONE, 16'd5, 0);
        cmd(C_DONE, 16'd6, 0);

        // R2 unmatched prediction
        expect_offer(16'd7, "R2 unmatched prediction");
        ins(LD, 16'd7, 16'd99, 1, 0, 0);
        drained("R2 unmatched drained");
        cmd(C_DONE, 16'd7, 0);

        // R3
        ins(ST, 16'd10, 16'd0, 0, 0, 0);
        ins(LD, 16'd11, 16'd10, 1, 0, 0);
        ins(LD, 16'd12, 16'd10, 0, 0, 0);
        drained("R3 dependents wait");
        expect_offer(16'd11, "R3 woken with regs");
        cmd(C_DONE, 16'd10, 0);
        drained("R3 only regs-ready one");
        expect_offer(16'd12, "R3 regs after wake");
        cmd(C_REGS, 16'd12, 0);
        drained("R3 drained");
        cmd(C_DONE, 16'd11, 0);
        cmd(C_DONE, 16'd12, 0);

        // R12
        ins(LD, 16'd13, 16'd0, 0, 0, 0);
        expect_offer(16'd14, "R12 load is no producer");
        ins(LD, 16'd14, 16'd13, 1, 0, 0);
        drained("R12 drained");
        cmd(C_DONE, 16'd13, 0);
        cmd(C_DONE, 16'd14, 0);

        // R4 full barrier
        ins(FB, 16'd20, 16'd0, 0, 0, 0);
        ins(LD, 16'd21, 16'd0, 1, 0, 0);
        ins(ST, 16'd22, 16'd0, 1, 0, 0);
        drained("R4 full barrier holds");
        expect_offer(16'd21, "R4 full barrier wake load");
        expect_offer(16'd22, "R4 full barrier wake store");
        cmd(C_DONE, 16'd20, 0);
        drained("R4 full drained");
        cmd(C_DONE, 16'd21, 0);
        cmd(C_DONE, 16'd22, 0);

        // R4 write barrier
        ins(WB, 16'd30, 16'd0, 0, 0, 0);
        expect_offer(16'd31, "R4 load bypasses write barrier");
        ins(LD, 16'd31, 16'd0, 1, 0, 0);
        ins(ST, 16'd32, 16'd0, 1, 0, 0);
        drained("R4 store held by write barrier");
        expect_offer(16'd32, "R4 write barrier wake");
        cmd(C_DONE, 16'd30, 0);
        drained("R4 write drained");
        cmd(C_DONE, 16'd31, 0);
        cmd(C_DONE, 16'd32, 0);

        // R6 override
        ins(ST, 16'd40, 16'd0, 0, 0, 0);
        ins(WB, 16'd41, 16'd0, 0, 0, 0);
        ins(ST, 16'd42, 16'd40, 1, 0, 0);
        drained("R6 waits on barrier");
        expect_offer(16'd42, "R6 barrier not predictor");
        cmd(C_DONE, 16'd41, 0);
        drained("R6 drained");
        cmd(C_DONE, 16'd42, 0);
        cmd(C_DONE, 16'd40, 0);

        // R5 sequence match
        ins(WB, 16'd50, 16'd0, 0, 0, 0);
        ins(WB, 16'd52, 16'd0, 0, 0, 0);
        cmd(C_DONE, 16'd50, 0);
        ins(ST, 16'd53, 16'd0, 1, 0, 0);
        drained("R5 younger barrier still in force");
        expect_offer(16'd53, "R5 younger barrier wake");
        cmd(C_DONE, 16'd52, 0);
        drained("R5 wake drained");
        expect_offer(16'd54, "R5 flag cleared");
        ins(ST, 16'd54, 16'd0, 1, 0, 0);
        drained("R5 drained");
        cmd(C_DONE, 16'd53, 0);
        cmd(C_DONE, 16'd54, 0);

        // R7 squash
        ins(ST, 16'd60, 16'd0, 0, 0, 0);
        ins(LD, 16'd65, 16'd60, 1, 0, 0);
        ins(LD, 16'd66, 16'd0, 0, 1, 0);
        cmd(C_SQUASH, 16'd62, 0);
        cmd(C_DONE, 16'd60, 0);
        drained("R7 squashed entry not woken");
        expect_offer(16'd66, "R7 other thread kept");
        cmd(C_REGS, 16'd66, 0);
        drained("R7 drained");
        cmd(C_DONE, 16'd66, 0);

        // R8 replay
        expect_offer(16'd70, "R8 first issue");
        ins(LD, 16'd70, 16'd0, 1, 0, 0);
        expect_offer(16'd71, "R8 first issue");
        ins(LD, 16'd71, 16'd0, 1, 0, 0);
        cmd(C_RESCH, 16'd71, 0);
        cmd(C_RESCH, 16'd70, 0);
        drained("R8 no offer before replay");
        expect_offer(16'd70, "R8 replay all oldest first");
        expect_offer(16'd71, "R8 replay all");
        cmd(C_REPLAY, 16'd71, 0);
        drained("R8 replay drained");
        cmd(C_RESCH, 16'd70, 0);
        expect_offer(16'd75, "R8 issue before squash");
        ins(LD, 16'd75, 16'd0, 1, 0, 0);
        cmd(C_RESCH, 16'd75, 0);
        cmd(C_SQUASH, 16'd72, 0);
        expect_offer(16'd70, "R8 squash drops queued younger");
        cmd(C_REPLAY, 16'd70, 0);
        drained("R8 drained");
        cmd(C_DONE, 16'd70, 0);
        cmd(C_DONE, 16'd71, 0);

        // R9 non-speculative
        ins(ST, 16'd80, 16'd0, 1, 0, 1);
        cmd(C_REGS, 16'd80, 0);
        drained("R9 held without release");
        expect_offer(16'd80, "R9 release");
        cmd(C_NS, 16'd80, 0);
        drained("R9 drained");
        cmd(C_DONE, 16'd80, 0);

        // R10 ordering and hold
        ins(ST, 16'd90, 16'd0, 0, 0, 0);
        ins(LD, 16'd97, 16'd90, 1, 0, 0);
        ins(LD, 16'd93, 16'd90, 1, 0, 0);
        expect_offer(16'd93, "R10 oldest first");
        expect_offer(16'd97, "R10 next oldest");
        cmd(C_DONE, 16'd90, 0);
        drained("R10 order drained");
        @(posedge clk); #2 take_en = 0;
        ins(LD, 16'd95, 16'd0, 1, 0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rdy_valid == 1 && rdy_seq == 16'd95, "R10 offer held", rdy_seq, 95);
        end
        expect_offer(16'd95, "R10 taken after hold");
        @(posedge clk); #2 take_en = 1;
        drained("R10 hold drained");
        cmd(C_DONE, 16'd93, 0);
        cmd(C_DONE, 16'd95, 0);
        cmd(C_DONE, 16'd97, 0);

        // R11 / R13 full table
        cmd(C_SQUASH, 16'd0, 0);
        cmd(C_SQUASH, 16'd0, 1);
        for (int k = 0; k < 16; k++)
            ins(ST, 16'(100 + k), 16'd0, 0, 0, 0);
        @(negedge clk);
        check(ins_ready == 0, "R11 full table", ins_ready, 0);
        cmd(C_DONE, 16'd100, 0);
        @(negedge clk);
        check(ins_ready == 1, "R13 slot freed", ins_ready, 1);
        cmd(C_SQUASH, 16'd0, 0);
        drained("R11 no stray offers");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule